// File: doc/BRIEF.md
# Receive Completion Entry Formatter

This block turns one received-packet record into a completion entry for a single completion queue. The entry leaves as a series of 32-bit words on a valid/ready stream. The record carries six fields: a base status word, extended status, a 16-bit partial TCP/UDP checksum, a buffer index, a VLAN ID with priority, and a packet timestamp.

A 2-bit format code, driven from a control register, sets the entry length to 1, 2 or 4 words and decides what each word holds. Every format starts with the same base status word. When the last word of an entry is accepted, the block pulses a completion strobe together with the entry length, so the queue write pointer can advance by that amount.

The block accepts one record at a time and emits its words in order. It holds the format code it sampled at acceptance for the whole entry.

Top module: `rxc_formatter`

## Requirements
- R1: After reset, `word_valid_o` is 0, `rec_ready_o` is 1 and `entry_done_o` is 0.
- R2: Format code 00 produces one word, equal to `rec_status_i`, with `word_last_o` = 1.
- R3: Format code 01 behaves exactly like code 00: one word equal to `rec_status_i`.
- R4: Format code 10 produces two words:
  - word 0 is `rec_status_i`;
  - word 1 is {`rec_ext_i` in bits 31:16, `rec_csum_i` in bits 15:0}.
- R5: Format code 11 produces four words:
  - word 0 is `rec_status_i`;
  - word 1 is {`rec_ext_i` in bits 31:16, `rec_buf_idx_i` in bits 15:0};
  - word 2 is {`rec_vlan_i` in bits 31:16, `rec_csum_i` in bits 15:0};
  - word 3 is `rec_tstamp_i`.
- R6: The format code is sampled in the cycle a record is accepted. Changing `cfg_fmt_i` afterwards does not change the length or content of the entry in progress.
- R7: `word_last_o` is 1 on the final word of each entry and 0 on every other word. Once a non-final word is accepted, the next word is presented in the following cycle.
- R8: While `word_valid_o` is 1 and `word_ready_i` is 0, `word_data_o` and `word_last_o` stay unchanged and `word_valid_o` stays 1.
- R9: `entry_done_o` is 1 exactly in the cycle the final word is accepted. In that cycle `entry_words_o` gives the entry length: 1, 2 or 4.
- R10: The record handshake works as follows:
  - `rec_ready_o` is 0 whenever an entry is being emitted;
  - word 0 of an accepted record is presented in the cycle after acceptance;
  - the block is ready again in the cycle after the final word is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_fmt_i | input | 2 | Completion format code |
| rec_valid_i | input | 1 | Packet record valid |
| rec_ready_o | output | 1 | Block can accept a record |
| rec_status_i | input | 32 | Base status word |
| rec_ext_i | input | 16 | Extended/additional status |
| rec_csum_i | input | 16 | Partial TCP/UDP checksum |
| rec_buf_idx_i | input | 16 | Index of first buffer used |
| rec_vlan_i | input | 16 | VLAN ID and priority |
| rec_tstamp_i | input | 32 | Packet timestamp |
| word_valid_o | output | 1 | Output word valid |
| word_ready_i | input | 1 | Downstream accepts word |
| word_data_o | output | 32 | Output word |
| word_last_o | output | 1 | Final word of entry |
| entry_done_o | output | 1 | Entry completed this cycle |
| entry_words_o | output | 3 | Words in completed entry |

## Verification
The assertions assume the following about the inputs:
- the record fields are valid in the cycle `rec_valid_i` and `rec_ready_o` are both high;
- `word_ready_i` may toggle freely;
- `cfg_fmt_i` may change at any time.

The stimulus works within these assumptions. It holds each record steady until acceptance, then changes the format code while the entry is still draining. It stalls the output with several ready patterns, which exercises the hold rule and the sampling of the format code.

// File: rtl/rxc_pkg.sv
package rxc_pkg;
  localparam int unsigned WORD_W    = 32;
  localparam int unsigned HALF_W    = WORD_W / 2;
  localparam int unsigned MAX_WORDS = 4;
  localparam int unsigned IDX_W     = $clog2(MAX_WORDS);
  localparam int unsigned CNT_W     = $clog2(MAX_WORDS + 1);

  typedef enum logic [1:0] {
    FMT_BASIC     = 2'b00,
    FMT_BASIC_ALT = 2'b01,
    FMT_CSUM      = 2'b10,
    FMT_FULL      = 2'b11
  } fmt_e;

  typedef struct packed {
    logic [WORD_W-1:0] status;
    logic [HALF_W-1:0] ext;
    logic [HALF_W-1:0] csum;
    logic [HALF_W-1:0] buf_idx;
    logic [HALF_W-1:0] vlan;
    logic [WORD_W-1:0] tstamp;
  } rec_t;
endpackage

// File: rtl/rxc_len_decode.sv
module rxc_len_decode
  import rxc_pkg::*;
(
  input  fmt_e             fmt_i,
  output logic [CNT_W-1:0] len_o
);
  always_comb begin
    unique case (fmt_i)
      FMT_CSUM: len_o = CNT_W'(2);
      FMT_FULL: len_o = CNT_W'(MAX_WORDS);
      default:  len_o = CNT_W'(1);
    endcase
  end
endmodule

// File: rtl/rxc_word_mux.sv
module rxc_word_mux
  import rxc_pkg::*;
(
  input  rec_t              rec_i,
  input  fmt_e              fmt_i,
  input  logic [IDX_W-1:0]  idx_i,
  output logic [WORD_W-1:0] word_o
);
  logic [WORD_W-1:0] words [MAX_WORDS];

  always_comb begin
    words[0] = rec_i.status;
    // word 1 low half: buffer index in the full format, checksum otherwise
    words[1] = (fmt_i == FMT_FULL) ? {rec_i.ext, rec_i.buf_idx}
                                   : {rec_i.ext, rec_i.csum};
    words[2] = {rec_i.vlan, rec_i.csum};
    words[3] = rec_i.tstamp;
  end

  assign word_o = words[idx_i];
endmodule

// File: rtl/rxc_seq.sv
module rxc_seq
  import rxc_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [CNT_W-1:0] len_i,
  input  logic             adv_i,
  output logic             busy_o,
  output logic [IDX_W-1:0] idx_o,
  output logic [CNT_W-1:0] len_o,
  output logic             last_o
);
  logic             busy_q;
  logic [IDX_W-1:0] idx_q;
  logic [CNT_W-1:0] len_q;

  assign last_o = busy_q && ((CNT_W'(idx_q) + CNT_W'(1)) == len_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      idx_q  <= '0;
      len_q  <= CNT_W'(1);
    end else if (start_i) begin
      busy_q <= 1'b1;
      idx_q  <= '0;
      len_q  <= len_i;
    end else if (adv_i) begin
      if (last_o) busy_q <= 1'b0;
      else        idx_q  <= idx_q + IDX_W'(1);
    end
  end

  assign busy_o = busy_q;
  assign idx_o  = idx_q;
  assign len_o  = len_q;
endmodule

// File: rtl/rxc_formatter.sv
module rxc_formatter
  import rxc_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [1:0]        cfg_fmt_i,
  input  logic              rec_valid_i,
  output logic              rec_ready_o,
  input  logic [WORD_W-1:0] rec_status_i,
  input  logic [HALF_W-1:0] rec_ext_i,
  input  logic [HALF_W-1:0] rec_csum_i,
  input  logic [HALF_W-1:0] rec_buf_idx_i,
  input  logic [HALF_W-1:0] rec_vlan_i,
  input  logic [WORD_W-1:0] rec_tstamp_i,
  output logic              word_valid_o,
  input  logic              word_ready_i,
  output logic [WORD_W-1:0] word_data_o,
  output logic              word_last_o,
  output logic              entry_done_o,
  output logic [CNT_W-1:0]  entry_words_o
);
  rec_t             rec_q;
  fmt_e             fmt_q;
  logic             busy, last, accept, adv;
  logic [IDX_W-1:0] idx;
  logic [CNT_W-1:0] start_len, len_q;

  assign rec_ready_o = !busy;
  assign accept      = rec_valid_i && rec_ready_o;
  assign adv         = busy && word_ready_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rec_q <= '0;
      fmt_q <= FMT_BASIC;
    end else if (accept) begin
      rec_q <= '{status: rec_status_i, ext: rec_ext_i, csum: rec_csum_i,
                 buf_idx: rec_buf_idx_i, vlan: rec_vlan_i, tstamp: rec_tstamp_i};
      fmt_q <= fmt_e'(cfg_fmt_i);
    end
  end

  rxc_len_decode u_len (
    .fmt_i (fmt_e'(cfg_fmt_i)),
    .len_o (start_len)
  );

  rxc_seq u_seq (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (accept),
    .len_i   (start_len),
    .adv_i   (adv),
    .busy_o  (busy),
    .idx_o   (idx),
    .len_o   (len_q),
    .last_o  (last)
  );

  rxc_word_mux u_mux (
    .rec_i  (rec_q),
    .fmt_i  (fmt_q),
    .idx_i  (idx),
    .word_o (word_data_o)
  );

  assign word_valid_o  = busy;
  assign word_last_o   = last;
  assign entry_done_o  = adv && last;
  assign entry_words_o = len_q;
endmodule

// File: rtl/rxc_formatter_chk.sv
module rxc_formatter_chk
  import rxc_pkg::*;
(
  input logic              clk_i,
  input logic              rst_ni,
  input logic [1:0]        cfg_fmt_i,
  input logic              rec_valid_i,
  input logic              rec_ready_o,
  input logic [WORD_W-1:0] rec_status_i,
  input logic              word_valid_o,
  input logic              word_ready_i,
  input logic [WORD_W-1:0] word_data_o,
  input logic              word_last_o,
  input logic              entry_done_o,
  input logic [CNT_W-1:0]  entry_words_o
);
  assert_hold_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    word_valid_o && !word_ready_i |=> word_valid_o && $stable(word_data_o) && $stable(word_last_o));

  assert_busy_blocks_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    word_valid_o |-> !rec_ready_o);

  assert_first_word_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rec_valid_i && rec_ready_o |=> word_valid_o && word_data_o == $past(rec_status_i));

  assert_ready_after_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    entry_done_o |=> rec_ready_o && !word_valid_o);

  assert_len_legal_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    entry_done_o |-> (entry_words_o == 1 || entry_words_o == 2 || entry_words_o == 4));

  assert_continue_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    word_valid_o && word_ready_i && !word_last_o |=> word_valid_o);
endmodule

bind rxc_formatter rxc_formatter_chk u_chk (.*);

// File: tb/tb_rxc_formatter.sv
module tb_rxc_formatter;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  cfg_fmt = 2'b00;
  logic        rec_valid = 1'b0;
  logic        rec_ready;
  logic [31:0] st = '0, ts = '0;
  logic [15:0] ext = '0, cs = '0, bi = '0, vl = '0;
  logic        w_valid, w_ready = 1'b1, w_last, done;
  logic [31:0] w_data;
  logic [2:0]  words;

  int errors = 0, checks = 0;
  int ready_mode = 0;
  int cyc = 0;
  logic [35:0] expq [$];  // {data, last, entry length}

  always #10 clk = ~clk;

  rxc_formatter dut (
    .clk_i(clk), .rst_ni(rst_n), .cfg_fmt_i(cfg_fmt),
    .rec_valid_i(rec_valid), .rec_ready_o(rec_ready),
    .rec_status_i(st), .rec_ext_i(ext), .rec_csum_i(cs),
    .rec_buf_idx_i(bi), .rec_vlan_i(vl), .rec_tstamp_i(ts),
    .word_valid_o(w_valid), .word_ready_i(w_ready), .word_data_o(w_data),
    .word_last_o(w_last), .entry_done_o(done), .entry_words_o(words));

  task automatic check(input bit ok, input string req, input logic [35:0] act, input logic [35:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // ready pattern driver
  initial forever begin
    @(posedge clk); #1;
    cyc++;
    case (ready_mode)
      0: w_ready = 1'b1;
      1: w_ready = (cyc % 3) != 0;
      default: w_ready = (cyc % 5) >= 3;
    endcase
  end

  task automatic send(input logic [1:0] f, input int k);
    logic [31:0] s, t;
    logic [15:0] e, c, b, v;
    int n;
    s = 32'hA500_0000 + k; t = 32'h7000_0000 + k * 3;
    e = 16'hE000 + 16'(k); c = 16'hC000 + 16'(k); b = 16'h0B00 + 16'(k); v = 16'h5000 + 16'(k);
    n = (f == 2'b10) ? 2 : (f == 2'b11) ? 4 : 1;
    expq.push_back({s, n == 1, 3'(n)});                                // R2 R3 word 0
    if (n == 2) expq.push_back({e, c, 1'b1, 3'(n)});                   // R4
    if (n == 4) begin                                                  // R5
      expq.push_back({e, b, 1'b0, 3'(n)});
      expq.push_back({v, c, 1'b0, 3'(n)});
      expq.push_back({t, 1'b1, 3'(n)});
    end
    @(posedge clk); #1;
    rec_valid = 1'b1; cfg_fmt = f;
    st = s; ts = t; ext = e; cs = c; bi = b; vl = v;
    forever begin
      @(negedge clk);
      if (rec_ready) break;
    end
    @(posedge clk); #1;
    rec_valid = 1'b0;
    cfg_fmt = ~f;  // R6: register change while entry is drained
    st = '1; ts = '1; ext = '1; cs = '1; bi = '1; vl = '1;
  endtask

  // monitor / scoreboard
  logic        prev_stall = 1'b0;
  logic [32:0] prev_out;
  initial forever begin
    logic [35:0] e;
    @(negedge clk);
    if (rst_n) begin
      if (prev_stall)
        check(w_valid && {w_data, w_last} == prev_out, "R8", {2'b0, w_valid, w_data, w_last}, {3'b001, prev_out});
      prev_stall = w_valid && !w_ready;
      prev_out   = {w_data, w_last};
      if (w_valid && w_ready) begin
        check(!rec_ready, "R10", {35'b0, rec_ready}, 36'b0);
        if (expq.size() == 0) begin
          check(1'b0, "R7", {w_data, w_last, 3'b0}, 36'b0);
        end else begin
          e = expq.pop_front();
          check(w_data == e[35:4], "R2-5/R6 data", {w_data, 4'b0}, {e[35:4], 4'b0});
          check(w_last == e[3], "R7", {35'b0, w_last}, {35'b0, e[3]});
          check(done == e[3], "R9 done", {35'b0, done}, {35'b0, e[3]});
          if (e[3]) check(words == e[2:0], "R9 words", {33'b0, words}, {33'b0, e[2:0]});
        end
      end else begin
        check(!done, "R9 idle", {35'b0, done}, 36'b0);
      end
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    check(!w_valid && rec_ready && !done, "R1", {33'b0, w_valid, rec_ready, done}, 36'b010);
    rst_n = 1'b1;
    ready_mode = 0;
    send(2'b00, 1);   // R2
    send(2'b01, 2);   // R3
    send(2'b10, 3);   // R4
    send(2'b11, 4);   // R5
    ready_mode = 1;
    for (int i = 0; i < 8; i++) send(2'(i), 10 + i);
    ready_mode = 2;
    for (int i = 0; i < 8; i++) send(2'(3 - (i % 4)), 30 + i);
    while (expq.size() != 0 || w_valid) @(posedge clk);
    repeat (3) @(posedge clk);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule